// File: doc/BRIEF.md
# SD Card SPI-Mode Command Issuer with Response Polling

This block sends one command to a memory card that is running in SPI mode. It accepts a 6-bit command index, a 32-bit argument, a check byte and two mode bits. It builds the 6-byte command frame and passes it one byte at a time to an external byte-wide SPI shifter. After the frame it clocks filler bytes until the card answers with a status byte. It can also collect a 4-byte trailer that some commands return, such as the operating-conditions word or the interface-check echo. The bit shifter itself and any data-block phase are handled outside this block.

The block talks to the shifter with a single-outstanding request handshake. It raises `spi_start` for one cycle with the byte to send. The shifter answers with `spi_done` and the received byte. The card select line is owned by this block. In the normal mode it releases select at the end of the command and clocks one idle byte. In the keep-selected mode it leaves select low after a good response, so that a data phase run by another agent can continue the same transaction.

Top module: `sd_cmd_framer`

## Requirements
- R1: The command frame is six bytes sent in this order: `0x40 | index`, argument bits 31:24, 23:16, 15:8, 7:0, then `req_crc` exactly as given (0x95 suits only the reset command, 0x87 the interface-check command).
- R2: When a request is accepted, `cs_n` goes low and one 0xFF byte is clocked with `cs_n` low before the first frame byte.
- R3: After the frame, 0xFF bytes are clocked. The first received byte with bit 7 equal to 0 is taken as the status byte `r1`. Earlier bytes with bit 7 set are skipped, whatever their other bits hold.
- R4: At most POLL_LIMIT (16) poll bytes are clocked. A valid byte on the 16th poll is still accepted. If none arrives, `timeout` is 1 and `r1` reads 0xFF.
- R5: When `req_trailer` is 1 and a status byte arrived, four more 0xFF bytes are clocked. The bytes received are packed first-received-most-significant into `trailer`. Otherwise `trailer` reads 0.
- R6: In the normal mode (`req_keep_cs` = 0), `cs_n` rises after the status byte or the trailer. Then exactly one more 0xFF byte is clocked with `cs_n` high, and then `done` is raised.
- R7: In the keep-selected mode, after a valid status byte (and trailer, if requested), `cs_n` stays low and no extra byte is sent. `cs_n` stays low after `done` until a later request releases it.
- R8: On a timeout, `cs_n` is raised and one 0xFF byte is clocked in either mode.
- R9: Only one byte transfer is outstanding at a time. `spi_start` is a one-cycle pulse, and the next one comes only after `spi_done` for the previous byte.
- R10: `busy` is high from the cycle after acceptance until `done`. `done` is a one-cycle pulse. A `req_valid` seen while `busy` is high is ignored and starts no transfer.
- R11: After reset, `cs_n` is 1, `busy`, `done`, `spi_start` and `timeout` are 0, `r1` is 0xFF and `trailer` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a command (taken only when idle) |
| req_index | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_crc | input | 8 | Last frame byte (check value and end bit) |
| req_trailer | input | 1 | Collect a 4-byte trailer after the status byte |
| req_keep_cs | input | 1 | Leave select low after a good response |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| r1 | output | 8 | Status byte received (0xFF on timeout) |
| trailer | output | 32 | Trailer word, first byte most significant |
| timeout | output | 1 | No status byte within the poll limit |
| cs_n | output | 1 | Card select, active low |
| spi_start | output | 1 | Request one byte transfer |
| spi_tx | output | 8 | Byte to send |
| spi_done | input | 1 | Byte transfer finished |
| spi_rx | input | 8 | Byte received |

## Verification
The bench targets the poll boundary. A status byte on the sixteenth poll must be accepted, while one that never comes must give exactly sixteen polls. An off-by-one counter would either give up one byte early or clock a seventeenth. Filler bytes such as 0xC3, which have bit 7 set but are not 0xFF, must be skipped; a design that tested for 0xFF or for the whole byte would take them as a response. The bench checks that a timeout releases select even in the keep-selected mode. It also checks that select stays low across the idle gap after a keep-selected command. A design that mixed up the two end paths would show up as a wrong byte count or a wrong level of `cs_n` on the final byte. A request pulsed in the middle of a command must leave the frame and the byte count untouched.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEAD,
    S_FRAME,
    S_POLL,
    S_TRAIL,
    S_TAIL,
    S_DONE
  } seq_state_t;

  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam int         FRAME_LEN = 6;

  // Byte number pos (0..5) of a command frame.
  function automatic logic [7:0] frame_byte(input logic [5:0]  idx,
                                            input logic [31:0] arg,
                                            input logic [7:0]  crc,
                                            input logic [2:0]  pos);
    logic [7:0] b;
    case (pos)
      3'd0:    b = {2'b01, idx};
      3'd1:    b = arg[31:24];
      3'd2:    b = arg[23:16];
      3'd3:    b = arg[15:8];
      3'd4:    b = arg[7:0];
      3'd5:    b = crc;
      default: b = FILL_BYTE;
    endcase
    return b;
  endfunction

  // A status byte always has its top bit cleared.
  function automatic logic is_status(input logic [7:0] b);
    return ~b[7];
  endfunction

endpackage

// File: rtl/sd_poll_counter.sv
module sd_poll_counter #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(LIMIT - 1));

  // R4
  poll_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LIMIT));

  // R4
  no_inc_past_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> !last);
endmodule

// File: rtl/sd_trailer_shift.sv
module sd_trailer_shift #(
  parameter int NBYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               shift,
  input  logic [7:0]         din,
  output logic [8*NBYTES-1:0] value
);
  logic [7:0] lane [NBYTES];

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lane[i] <= '0;
      else if (clr)   lane[i] <= '0;
      else if (shift) lane[i] <= (i == 0) ? din : lane[(i == 0) ? 0 : i - 1];
    end
    assign value[8*i +: 8] = lane[i];
  end

  // R5
  newest_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !clr) |=> value[7:0] == $past(din));
endmodule

// File: rtl/sd_cmd_framer.sv
module sd_cmd_framer
  import sd_cmd_pkg::*;
#(
  parameter int POLL_LIMIT    = 16,
  parameter int TRAILER_BYTES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [5:0]                 req_index,
  input  logic [31:0]                req_arg,
  input  logic [7:0]                 req_crc,
  input  logic                       req_trailer,
  input  logic                       req_keep_cs,
  output logic                       busy,
  output logic                       done,
  output logic [7:0]                 r1,
  output logic [8*TRAILER_BYTES-1:0] trailer,
  output logic                       timeout,
  output logic                       cs_n,
  output logic                       spi_start,
  output logic [7:0]                 spi_tx,
  input  logic                       spi_done,
  input  logic [7:0]                 spi_rx
);
  localparam int TCW = $clog2(TRAILER_BYTES + 1);

  seq_state_t     state;
  logic           pending;
  logic [2:0]     pos;
  logic [TCW-1:0] tcnt;
  logic [5:0]     lat_idx;
  logic [31:0]    lat_arg;
  logic [7:0]     lat_crc;
  logic           lat_trl;
  logic           lat_keep;

  // Named events
  logic       accept, issue, byte_done, rx_ok, poll_last;
  logic       poll_inc, give_up, trl_shift, trl_last, frame_last;
  logic [7:0] tx_next;

  assign accept     = (state == S_IDLE) && req_valid;
  assign issue      = (state inside {S_LEAD, S_FRAME, S_POLL, S_TRAIL, S_TAIL}) && !pending;
  assign byte_done  = pending && spi_done;
  assign rx_ok      = is_status(spi_rx);
  assign poll_inc   = byte_done && (state == S_POLL) && !rx_ok && !poll_last;
  assign give_up    = byte_done && (state == S_POLL) && !rx_ok && poll_last;
  assign trl_shift  = byte_done && (state == S_TRAIL);
  assign trl_last   = (tcnt == TCW'(TRAILER_BYTES - 1));
  assign frame_last = (pos == 3'(FRAME_LEN - 1));
  assign tx_next    = (state == S_FRAME) ? frame_byte(lat_idx, lat_arg, lat_crc, pos)
                                         : FILL_BYTE;

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  sd_poll_counter #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (accept),
    .inc  (poll_inc),
    .last (poll_last)
  );

  sd_trailer_shift #(.NBYTES(TRAILER_BYTES)) u_trl (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (accept),
    .shift(trl_shift),
    .din  (spi_rx),
    .value(trailer)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      pending   <= 1'b0;
      pos       <= '0;
      tcnt      <= '0;
      lat_idx   <= '0;
      lat_arg   <= '0;
      lat_crc   <= '0;
      lat_trl   <= 1'b0;
      lat_keep  <= 1'b0;
      cs_n      <= 1'b1;
      r1        <= FILL_BYTE;
      timeout   <= 1'b0;
      spi_start <= 1'b0;
      spi_tx    <= FILL_BYTE;
    end else begin
      spi_start <= 1'b0;
      if (issue) begin
        spi_start <= 1'b1;
        spi_tx    <= tx_next;
        pending   <= 1'b1;
      end
      if (byte_done) pending <= 1'b0;

      case (state)
        S_IDLE: if (accept) begin
          lat_idx  <= req_index;
          lat_arg  <= req_arg;
          lat_crc  <= req_crc;
          lat_trl  <= req_trailer;
          lat_keep <= req_keep_cs;
          cs_n     <= 1'b0;
          r1       <= FILL_BYTE;
          timeout  <= 1'b0;
          pos      <= '0;
          tcnt     <= '0;
          state    <= S_LEAD;
        end
        S_LEAD: if (byte_done) state <= S_FRAME;
        S_FRAME: if (byte_done) begin
          pos <= pos + 3'd1;
          if (frame_last) state <= S_POLL;
        end
        S_POLL: if (byte_done) begin
          if (rx_ok) begin
            r1 <= spi_rx;
            if (lat_trl)       state <= S_TRAIL;
            else if (lat_keep) state <= S_DONE;
            else begin
              cs_n  <= 1'b1;
              state <= S_TAIL;
            end
          end else if (poll_last) begin
            timeout <= 1'b1;
            cs_n    <= 1'b1;
            state   <= S_TAIL;
          end
        end
        S_TRAIL: if (byte_done) begin
          tcnt <= tcnt + 1'b1;
          if (trl_last) begin
            if (lat_keep) state <= S_DONE;
            else begin
              cs_n  <= 1'b1;
              state <= S_TAIL;
            end
          end
        end
        S_TAIL: if (byte_done) state <= S_DONE;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |=> !spi_start);

  // R9
  no_done_unrequested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> !spi_done);

  // R2
  lead_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_start && state == S_LEAD) |-> !cs_n);

  // R6
  tail_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_start && state == S_TAIL) |-> cs_n);

  // R8
  timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timeout) |-> cs_n);

  // R4
  status_top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !timeout) |-> !r1[7]);

  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/test_sd_cmd_framer.sv
module test_sd_cmd_framer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  req_index = '0;
  logic [31:0] req_arg = '0;
  logic [7:0]  req_crc = '0;
  logic        req_trailer = 1'b0;
  logic        req_keep_cs = 1'b0;
  logic        busy, done, timeout, cs_n, spi_start;
  logic [7:0]  r1, spi_tx;
  logic [31:0] trailer;
  logic        spi_done;
  logic [7:0]  spi_rx;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  sd_cmd_framer i_sd_cmd_framer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_index(req_index),
    .req_arg(req_arg), .req_crc(req_crc), .req_trailer(req_trailer),
    .req_keep_cs(req_keep_cs), .busy(busy), .done(done), .r1(r1),
    .trailer(trailer), .timeout(timeout), .cs_n(cs_n), .spi_start(spi_start),
    .spi_tx(spi_tx), .spi_done(spi_done), .spi_rx(spi_rx)
  );

  // Card and shifter model: answers each byte three cycles later.
  int         nxfer = 0;
  int         base = 0;
  int         overlap = 0;
  int         sc_fill = 0;
  logic [7:0] sc_r1 = 8'h00;
  logic [31:0] sc_tv = '0;
  logic [7:0] sc_junk = 8'hFF;
  logic [7:0] tx_log [0:1023];
  logic       cs_log [0:1023];
  logic       m_busy;
  int         m_dly;
  logic [7:0] m_rx;

  function automatic logic [7:0] card_byte(input int k);
    int p;
    if (k < 7) return 8'hFF;
    p = k - 7;
    if (p < sc_fill) return sc_junk;
    if (p == sc_fill) return sc_r1;
    if (p <= sc_fill + 4) return 8'(sc_tv >> (8 * (4 - (p - sc_fill))));
    return 8'hFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      spi_done <= 1'b0;
      spi_rx   <= 8'hFF;
      m_busy   <= 1'b0;
      m_dly    <= 0;
    end else begin
      spi_done <= 1'b0;
      if (spi_start) begin
        if (m_busy) overlap <= overlap + 1;
        tx_log[nxfer & 1023] <= spi_tx;
        cs_log[nxfer & 1023] <= cs_n;
        m_rx   <= card_byte(nxfer - base);
        nxfer  <= nxfer + 1;
        m_busy <= 1'b1;
        m_dly  <= 2;
      end else if (m_busy) begin
        if (m_dly == 0) begin
          spi_done <= 1'b1;
          spi_rx   <= m_rx;
          m_busy   <= 1'b0;
        end else m_dly <= m_dly - 1;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary_and_end();
    end
  end

  // One complete command with its own checks.
  task automatic run_cmd(input string tag, input logic [5:0] idx, input logic [31:0] arg,
                         input logic [7:0] crc, input bit trl, input bit keep,
                         input int fill, input logic [7:0] r1v, input logic [31:0] tv,
                         input logic [7:0] junk, input bit poke);
    bit   timed;
    int   npoll, exp_n, got, w, badf, badp, badcs;
    logic [7:0] eb;
    timed = (fill >= 16);
    npoll = timed ? 16 : fill + 1;
    exp_n = 7 + npoll + ((!timed && trl) ? 4 : 0) + ((timed || !keep) ? 1 : 0);
    sc_fill = fill; sc_r1 = r1v; sc_tv = tv; sc_junk = junk;
    @(negedge clk);
    base = nxfer;
    req_index = idx; req_arg = arg; req_crc = crc;
    req_trailer = trl; req_keep_cs = keep; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", {tag, " busy after accept"}, 32'(busy), 32'd1);
    w = 0;
    while (!done && w < 3000) begin
      @(negedge clk);
      w++;
      if (poke && w == 12) begin
        req_index = idx ^ 6'h3F; req_arg = ~arg; req_valid = 1'b1;
      end else req_valid = 1'b0;
    end
    req_valid = 1'b0;
    chk("R10", {tag, " done seen"}, 32'(done), 32'd1);
    got = nxfer - base;
    chk("R6", {tag, " byte count"}, 32'(got), 32'(exp_n));
    // lead byte
    chk("R2", {tag, " lead byte"}, 32'(tx_log[base & 1023]), 32'hFF);
    chk("R2", {tag, " lead select"}, 32'(cs_log[base & 1023]), 32'd0);
    // frame bytes
    badf = 0;
    for (int k = 1; k <= 6; k++) begin
      case (k)
        1: eb = 8'h40 | {2'b00, idx};
        6: eb = crc;
        default: eb = 8'(arg >> (8 * (5 - k)));
      endcase
      if (tx_log[(base + k) & 1023] !== eb) badf++;
    end
    chk("R1", {tag, " frame mismatches"}, 32'(badf), 32'd0);
    // filler after frame, select low until tail
    badp = 0; badcs = 0;
    for (int k = 7; k < got; k++) begin
      if (tx_log[(base + k) & 1023] !== 8'hFF) badp++;
      if ((timed || !keep) && k == got - 1) begin
        if (cs_log[(base + k) & 1023] !== 1'b1) badcs++;
      end else if (cs_log[(base + k) & 1023] !== 1'b0) badcs++;
    end
    chk("R3", {tag, " poll filler mismatches"}, 32'(badp), 32'd0);
    chk(timed ? "R8" : (keep ? "R7" : "R6"), {tag, " select per byte"}, 32'(badcs), 32'd0);
    chk("R4", {tag, " timeout"}, 32'(timeout), 32'(timed));
    chk("R3", {tag, " status byte"}, 32'(r1), timed ? 32'hFF : 32'(r1v));
    chk("R5", {tag, " trailer"}, trailer, (!timed && trl) ? tv : 32'h0);
    chk(timed ? "R8" : (keep ? "R7" : "R6"), {tag, " select after done"},
        32'(cs_n), (timed || !keep) ? 32'd1 : 32'd0);
    chk("R9", {tag, " overlapping transfers"}, 32'(overlap), 32'd0);
    @(negedge clk);
    chk("R10", {tag, " done one cycle"}, 32'(done), 32'd0);
    if (poke) begin
      repeat (10) @(negedge clk);
      chk("R10", {tag, " ignored request made no bytes"}, 32'(nxfer - base), 32'(exp_n));
      chk("R10", {tag, " idle after ignored request"}, 32'(busy), 32'd0);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R11", "cs_n", 32'(cs_n), 32'd1);
    chk("R11", "busy", 32'(busy), 32'd0);
    chk("R11", "done", 32'(done), 32'd0);
    chk("R11", "spi_start", 32'(spi_start), 32'd0);
    chk("R11", "timeout", 32'(timeout), 32'd0);
    chk("R11", "r1", 32'(r1), 32'hFF);
    chk("R11", "trailer", trailer, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_keep_hold();
    run_cmd("keep", 6'd17, 32'h0000_1200, 8'h95, 1'b0, 1'b1, 0, 8'h00, 32'h0, 8'hFF, 1'b0);
    repeat (6) @(negedge clk);
    chk("R7", "select held in gap", 32'(cs_n), 32'd0);
    chk("R7", "no bytes in gap", 32'(spi_start), 32'd0);
    run_cmd("after_keep", 6'd13, 32'h0, 8'h95, 1'b0, 1'b0, 0, 8'h00, 32'h0, 8'hFF, 1'b0);
  endtask

  initial begin
    t_reset();
    run_cmd("reset_cmd", 6'd0, 32'h0, 8'h95, 1'b0, 1'b0, 2, 8'h01, 32'h0, 8'hFF, 1'b0);
    run_cmd("if_check", 6'd8, 32'h0000_01AA, 8'h87, 1'b1, 1'b0, 1, 8'h01, 32'h0000_01AA, 8'hFF, 1'b0);
    run_cmd("ocr_read", 6'd58, 32'h0, 8'h95, 1'b1, 1'b0, 0, 8'h00, 32'hC0FF_8000, 8'hFF, 1'b0);
    run_cmd("junk_skip", 6'd55, 32'hA5C3_1E78, 8'h65, 1'b0, 1'b0, 5, 8'h05, 32'h0, 8'hC3, 1'b0);
    run_cmd("last_poll", 6'd41, 32'h4000_0000, 8'h77, 1'b0, 1'b0, 15, 8'h00, 32'h0, 8'hFF, 1'b0);
    run_cmd("timeout", 6'd9, 32'h1234_5678, 8'h95, 1'b1, 1'b0, 16, 8'h00, 32'h0, 8'hFF, 1'b0);
    run_cmd("timeout_keep", 6'd24, 32'h0000_0400, 8'h95, 1'b0, 1'b1, 16, 8'h00, 32'h0, 8'h80, 1'b0);
    t_keep_hold();
    run_cmd("keep_trail", 6'd58, 32'h0, 8'h95, 1'b1, 1'b1, 3, 8'h00, 32'h8001_0203, 8'hFF, 1'b0);
    run_cmd("poke_busy", 6'd16, 32'h0000_0200, 8'h15, 1'b0, 1'b0, 1, 8'h00, 32'h0, 8'hFF, 1'b1);
    summary_and_end();
  end
endmodule